// File: doc/BRIEF.md
# System Reset Sequencer

This block decides when the processor core of a small microcontroller is held in reset, and for how long. It collects reset requests from a power-on detector, a low-supply detector, a watchdog, the core's illegal-opcode and illegal-address traps, and a dual-purpose external reset pin. Requests that arrive without regard to the clock are brought into the clock domain first. One winner is picked by a fixed priority, and a timed sequence runs from it.

For supply-related events the sequence begins with a long window with the pin pulled low. Every internal sequence then has a short pin-drive window, which also resets chips on the board, followed by a hold window in which only the core stays in reset. The pin is open-drain: the block only asserts an output enable that pulls the line low. After power-on the pin is a plain input. It takes on its reset role only after a configuration bit is written to 1, and that bit keeps its value through every reset except power-on. A one-hot cause register shows which source started the most recent reset.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is high with no clock edge needed. After one clock edge with `por_i` high, `cause_o` is 6'b000001 and `pin_en_o` is 0.
- R2: After `por_i` falls, `core_rst_o` stays high for exactly 4160 clock cycles (4096 long + 32 drive + 32 hold).
- R3: A cycle with `cfg_wr_i` high loads `cfg_en_i` into `pin_en_o`. The value is kept through every reset except power-on.
- R4: A watchdog, illegal-opcode or illegal-address reset holds `pin_oe_o` high for exactly 32 cycles, starting in the first cycle of `core_rst_o`. `core_rst_o` then stays high for 32 more cycles, 64 in total.
- R5: A low-supply request held for L synchronized cycles keeps `pin_oe_o` high for L-1+4128 cycles. `core_rst_o` ends 32 cycles after that.
- R6: `pin_oe_o` is high only while `pin_en_o` is 1. With the pin function off, internal resets keep their full `core_rst_o` length and the pin is never driven.
- R7: With `pin_en_o` at 1, the pin read low for at least 4 consecutive synchronized cycles causes a reset with cause PIN, and `pin_oe_o` stays 0. Counting from the cycle in which the pin is released, `core_rst_o` stays high for 34 more sampled cycles (2 synchronizer stages, 1 cycle to leave the pin state, and 31 further hold cycles).
- R8: A low pin pulse shorter than 4 synchronized cycles, or any low pin while `pin_en_o` is 0, causes no reset and leaves `cause_o` unchanged.
- R9: `cause_o` is one-hot with bit 0 power-on, bit 1 pin, bit 2 watchdog, bit 3 illegal opcode, bit 4 illegal address and bit 5 low supply. It changes only while `core_rst_o` is high.
- R10: Requests that are present together are ranked low supply, then pin, then watchdog, then illegal opcode, then illegal address. Power-on overrides all of them.
- R11: A request accepted during a running sequence restarts the sequence from its first window and overwrites `cause_o`, with no gap in `core_rst_o`.
- R12: Low-supply, watchdog and pin inputs pass through a two-stage synchronizer. A watchdog request held high for several cycles starts only one reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| por_i | input | 1 | Power-on request, active high, also the synchronous reset of the block |
| lvi_i | input | 1 | Low-supply request, asynchronous level |
| cop_i | input | 1 | Watchdog timeout request, asynchronous |
| ilop_i | input | 1 | Illegal-opcode trap, synchronous one-cycle pulse |
| ilad_i | input | 1 | Illegal-address trap, synchronous one-cycle pulse |
| pin_i | input | 1 | Level read back from the reset pin |
| cfg_wr_i | input | 1 | Write strobe for the pin-function enable |
| cfg_en_i | input | 1 | Value written to the pin-function enable |
| pin_oe_o | output | 1 | Pulls the reset pin low when high |
| core_rst_o | output | 1 | Internal reset to the core |
| pin_en_o | output | 1 | Current pin-function enable |
| cause_o | output | 6 | One-hot cause of the last reset |

## Verification
A trap pulse presented before a clock edge starts reset at that edge. A watchdog or low-supply input reaches the sequencer two edges later, and a pin low is accepted at the sixth edge after it falls. The bench therefore never relies on when a reset starts. It measures window lengths by counting negedge samples from the first sample in which `core_rst_o` is high. The release of the pin reset is timed from the release itself, with the last high sample expected 34 samples later. For ignored stimulus, the bench watches `core_rst_o` and `cause_o` over a window longer than the 6-edge acceptance delay.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    localparam int NSRC   = 6;
    localparam int B_POR  = 0;
    localparam int B_PIN  = 1;
    localparam int B_COP  = 2;
    localparam int B_ILOP = 3;
    localparam int B_ILAD = 4;
    localparam int B_LVI  = 5;

    typedef logic [NSRC-1:0] cause_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LONG  = 3'd1,
        ST_DRIVE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_EXT   = 3'd4
    } seq_st_t;

    typedef struct packed {
        logic lvi;
        logic pin;
        logic cop;
        logic ilop;
        logic ilad;
    } req_t;

    typedef struct packed {
        logic    valid;
        cause_t  cause;
        seq_st_t entry;
    } win_t;

    function automatic cause_t src_bit(input int idx);
        return cause_t'(1) << idx;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Fixed priority: supply, pin, watchdog, opcode, address.
    function automatic win_t arbitrate(input req_t r);
        win_t w;
        w.valid = 1'b1;
        if (r.lvi) begin
            w.cause = src_bit(B_LVI);
            w.entry = ST_LONG;
        end else if (r.pin) begin
            w.cause = src_bit(B_PIN);
            w.entry = ST_EXT;
        end else if (r.cop) begin
            w.cause = src_bit(B_COP);
            w.entry = ST_DRIVE;
        end else if (r.ilop) begin
            w.cause = src_bit(B_ILOP);
            w.entry = ST_DRIVE;
        end else if (r.ilad) begin
            w.cause = src_bit(B_ILAD);
            w.entry = ST_DRIVE;
        end else begin
            w.valid = 1'b0;
            w.cause = '0;
            w.entry = ST_IDLE;
        end
        return w;
    endfunction

    function automatic logic drives_pin(input seq_st_t s);
        return (s == ST_LONG) || (s == ST_DRIVE);
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_seq_pin_qual.sv
module rst_seq_pin_qual #(
    parameter int PIN_MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    input  logic en,
    input  logic oe,
    output logic req
);
    localparam int QW = (PIN_MIN > 1) ? $clog2(PIN_MIN) : 1;
    localparam logic [QW-1:0] QTOP = QW'(PIN_MIN - 1);

    logic [QW-1:0] run;
    logic          low_now;

    // Pin low counts only when enabled and not driven by this block.
    assign low_now = en && !pin_s && !oe;

    always_ff @(posedge clk) begin
        if (rst || !low_now)  run <= '0;
        else if (run != QTOP) run <= run + 1'b1;
    end

    assign req = low_now && (run == QTOP);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int LONG_CYC = 4096,
    parameter int DRV_CYC  = 32,
    parameter int HOLD_CYC = 32
) (
    input  logic    clk,
    input  logic    por,
    input  req_t    req,
    output seq_st_t st_o,
    output cause_t  cause_o
);
    localparam int MAXC  = max3(LONG_CYC, DRV_CYC, HOLD_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LONG_END = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] DRV_END  = CNT_W'(DRV_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYC - 1);

    seq_st_t          st;
    logic [CNT_W-1:0] cnt;
    cause_t           cause;
    win_t             win;

    always_comb win = arbitrate(req);

    always_ff @(posedge clk) begin
        if (por) begin
            st    <= ST_LONG;
            cnt   <= '0;
            cause <= src_bit(B_POR);
        end else if (win.valid) begin
            st    <= win.entry;
            cnt   <= '0;
            cause <= win.cause;
        end else begin
            case (st)
                ST_LONG: begin
                    if (cnt == LONG_END) begin
                        st  <= ST_DRIVE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRIVE: begin
                    if (cnt == DRV_END) begin
                        st  <= ST_HOLD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == HOLD_END) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_EXT: begin
                    st  <= ST_HOLD;
                    cnt <= '0;
                end
                default: begin
                    st  <= ST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign st_o    = st;
    assign cause_o = cause;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int LONG_CYC    = 4096,
    parameter int DRV_CYC     = 32,
    parameter int HOLD_CYC    = 32,
    parameter int PIN_MIN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            por_i,
    input  logic            lvi_i,
    input  logic            cop_i,
    input  logic            ilop_i,
    input  logic            ilad_i,
    input  logic            pin_i,
    input  logic            cfg_wr_i,
    input  logic            cfg_en_i,
    output logic            pin_oe_o,
    output logic            core_rst_o,
    output logic            pin_en_o,
    output logic [NSRC-1:0] cause_o
);
    localparam int NASYNC = 3;
    localparam int A_LVI  = 0;
    localparam int A_COP  = 1;
    localparam int A_PIN  = 2;
    // Idle level of each async input: the pin idles high (pulled up).
    localparam logic [NASYNC-1:0] IDLE_LVL = 3'b100;

    logic [NASYNC-1:0] a_raw;
    logic [NASYNC-1:0] a_syn;
    logic              cop_d;
    logic              pin_en;
    logic              pin_req;
    req_t              req;
    seq_st_t           st;
    cause_t            cause;

    assign a_raw[A_LVI] = lvi_i;
    assign a_raw[A_COP] = cop_i;
    assign a_raw[A_PIN] = pin_i;

    generate
        for (genvar g = 0; g < NASYNC; g++) begin : g_sync
            rst_seq_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(IDLE_LVL[g])
            ) u_sync (
                .clk(clk),
                .rst(por_i),
                .d  (a_raw[g]),
                .q  (a_syn[g])
            );
        end
    endgenerate

    // Watchdog request is taken once per rising edge.
    always_ff @(posedge clk) begin
        if (por_i) cop_d <= 1'b0;
        else       cop_d <= a_syn[A_COP];
    end

    // Pin-function enable: cleared by power-on only.
    always_ff @(posedge clk) begin
        if (por_i)         pin_en <= 1'b0;
        else if (cfg_wr_i) pin_en <= cfg_en_i;
    end

    assign pin_oe_o = pin_en && drives_pin(st);

    rst_seq_pin_qual #(
        .PIN_MIN(PIN_MIN)
    ) u_qual (
        .clk  (clk),
        .rst  (por_i),
        .pin_s(a_syn[A_PIN]),
        .en   (pin_en),
        .oe   (pin_oe_o),
        .req  (pin_req)
    );

    always_comb begin
        req.lvi  = a_syn[A_LVI];
        req.pin  = pin_req;
        req.cop  = a_syn[A_COP] && !cop_d;
        req.ilop = ilop_i;
        req.ilad = ilad_i;
    end

    rst_seq_ctrl #(
        .LONG_CYC(LONG_CYC),
        .DRV_CYC (DRV_CYC),
        .HOLD_CYC(HOLD_CYC)
    ) u_ctrl (
        .clk    (clk),
        .por    (por_i),
        .req    (req),
        .st_o   (st),
        .cause_o(cause)
    );

    assign core_rst_o = por_i || (st != ST_IDLE);
    assign pin_en_o   = pin_en;
    assign cause_o    = cause;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int NS = 6
) (
    input logic          clk,
    input logic          por_i,
    input logic          cfg_wr_i,
    input logic          ilop_i,
    input logic          pin_oe_o,
    input logic          core_rst_o,
    input logic          pin_en_o,
    input logic [NS-1:0] cause_o
);
    // R1: power-on forces the core reset without waiting for a clock
    always_comb begin
        if (por_i === 1'b1) begin
            p_por_force_r1: assert (core_rst_o === 1'b1);
        end
    end

    p_oe_needs_en_r6: assert property (@(posedge clk) disable iff (por_i)
        pin_oe_o |-> pin_en_o);

    p_oe_in_reset_r4: assert property (@(posedge clk) disable iff (por_i)
        pin_oe_o |-> core_rst_o);

    p_hold_after_drive_r4: assert property (@(posedge clk) disable iff (por_i)
        $fell(pin_oe_o) |-> core_rst_o);

    p_trap_starts_r11: assert property (@(posedge clk) disable iff (por_i)
        ilop_i |=> core_rst_o);

    p_cause_onehot_r9: assert property (@(posedge clk) disable iff (por_i)
        $countones(cause_o) == 1);

    p_cause_in_reset_r9: assert property (@(posedge clk) disable iff (por_i)
        !$stable(cause_o) |-> core_rst_o);

    p_en_kept_r3: assert property (@(posedge clk) disable iff (por_i)
        !cfg_wr_i |=> $stable(pin_en_o));
endmodule

bind rst_seq_top rst_seq_chk #(.NS(rst_seq_pkg::NSRC)) u_chk (
    .clk       (clk),
    .por_i     (por_i),
    .cfg_wr_i  (cfg_wr_i),
    .ilop_i    (ilop_i),
    .pin_oe_o  (pin_oe_o),
    .core_rst_o(core_rst_o),
    .pin_en_o  (pin_en_o),
    .cause_o   (cause_o)
);

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       lvi = 1'b0, cop = 1'b0, ilop = 1'b0, ilad = 1'b0;
    logic       ext_low = 1'b0;
    logic       cfg_wr = 1'b0, cfg_en = 1'b0;
    logic       pin_line;
    logic       pin_oe, core_rst, pin_en;
    logic [5:0] cause;
    int         tests = 0;
    int         fails = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    // Open-drain line with pullup: low if the block or the board pulls it.
    assign pin_line = ~(pin_oe | ext_low);

    rst_seq_top u0 (
        .clk(clk), .por_i(por), .lvi_i(lvi), .cop_i(cop), .ilop_i(ilop),
        .ilad_i(ilad), .pin_i(pin_line), .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en),
        .pin_oe_o(pin_oe), .core_rst_o(core_rst), .pin_en_o(pin_en),
        .cause_o(cause)
    );

    localparam int K_COP = 0, K_ILOP = 1, K_ILAD = 2;

    function automatic int exp_cause(input int kind);
        case (kind)
            K_COP:   return 6'b000100;
            K_ILOP:  return 6'b001000;
            default: return 6'b010000;
        endcase
    endfunction
    function automatic int exp_fault_oe(input bit en);
        return en ? 32 : 0;
    endfunction
    function automatic int exp_lvi_oe(input int l, input bit en);
        return en ? (l - 1 + 4096 + 32) : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic measure(output int oe_w, output int rst_w);
        int t = 0;
        oe_w = 0;
        rst_w = 0;
        while (!core_rst && t < 200) begin @(negedge clk); t++; end
        while (core_rst && rst_w < 20000) begin
            if (pin_oe) oe_w++;
            rst_w++;
            @(negedge clk);
        end
    endtask

    task automatic write_en(input bit v);
        @(negedge clk); cfg_wr = 1'b1; cfg_en = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic fault(input int kind, input int hold);
        @(negedge clk);
        case (kind)
            K_COP:  begin cop = 1'b1; repeat (hold) @(negedge clk); cop = 1'b0; end
            K_ILOP: begin ilop = 1'b1; @(negedge clk); ilop = 1'b0; end
            default: begin ilad = 1'b1; @(negedge clk); ilad = 1'b0; end
        endcase
    endtask

    task automatic run_fault(input string req, input int kind, input int hold, input bit en);
        int ow, rw;
        fork fault(kind, hold); join_none
        measure(ow, rw);
        chk(req, "fault pin drive width", ow, exp_fault_oe(en));
        chk(req, "fault core reset width", rw, 64);
        chk("R9", "fault cause", int'(cause), exp_cause(kind));
        repeat (8) @(negedge clk);
    endtask

    task automatic pin_case(input string req, input int n, input bit expect_rst, input int cause_before);
        int last_high = 0;
        int oe_seen = 0;
        @(negedge clk); ext_low = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (pin_oe) oe_seen++;
        end
        ext_low = 1'b0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (core_rst) last_high = k;
            if (pin_oe) oe_seen++;
        end
        chk(req, "pin release to last reset sample", last_high, expect_rst ? 34 : 0);
        chk(req, "pin never driven by block on pin reset", oe_seen, 0);
        chk(req, "cause after pin stimulus", int'(cause), expect_rst ? 6'b000010 : cause_before);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog all: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ow, rw, kind, hold;
        bit en;
        void'($urandom(32'd51423));

        // R1: power-on state
        repeat (3) @(negedge clk);
        chk("R1", "core reset during power-on", int'(core_rst), 1);
        chk("R1", "cause during power-on", int'(cause), 6'b000001);
        chk("R1", "enable during power-on", int'(pin_en), 0);
        chk("R6", "no pin drive during power-on", int'(pin_oe), 0);

        // R2: power-on release length; pin stays released with enable off
        por = 1'b0;
        rw = 0; ow = 0;
        while (core_rst && rw < 20000) begin
            if (pin_oe) ow++;
            rw++;
            @(negedge clk);
        end
        chk("R2", "power-on core reset width", rw, 4160);
        chk("R6", "power-on pin drive with enable off", ow, 0);

        // R3: enable write
        write_en(1'b1);
        chk("R3", "enable after write", int'(pin_en), 1);

        // R4: directed faults
        run_fault("R4", K_ILOP, 1, 1'b1);
        chk("R3", "enable kept through fault reset", int'(pin_en), 1);
        // R12: long watchdog level gives one sequence
        run_fault("R12", K_COP, 10, 1'b1);
        run_fault("R4", K_ILAD, 1, 1'b1);

        // R5 and R10: low supply held 3 cycles together with watchdog
        fork
            begin
                @(negedge clk); lvi = 1'b1; cop = 1'b1;
                repeat (3) @(negedge clk); lvi = 1'b0; cop = 1'b0;
            end
        join_none
        measure(ow, rw);
        chk("R5", "low supply pin drive width", ow, exp_lvi_oe(3, 1'b1));
        chk("R5", "low supply core reset width", rw, exp_lvi_oe(3, 1'b1) + 32);
        chk("R10", "low supply wins over watchdog", int'(cause), 6'b100000);
        repeat (8) @(negedge clk);

        // R10: opcode beats address in the same cycle
        fork
            begin
                @(negedge clk); ilop = 1'b1; ilad = 1'b1;
                @(negedge clk); ilop = 1'b0; ilad = 1'b0;
            end
        join_none
        measure(ow, rw);
        chk("R10", "opcode wins over address", int'(cause), 6'b001000);
        repeat (8) @(negedge clk);

        // R11: restart during hold window
        fork
            begin
                @(negedge clk); ilop = 1'b1;
                @(negedge clk); ilop = 1'b0;
                repeat (38) @(negedge clk);
                ilad = 1'b1;
                @(negedge clk); ilad = 1'b0;
            end
        join_none
        measure(ow, rw);
        chk("R11", "restart total pin drive", ow, 64);
        chk("R11", "restart unbroken core reset", rw, 103);
        chk("R11", "restart cause", int'(cause), 6'b010000);
        repeat (8) @(negedge clk);

        // R7, R8: pin reset boundaries
        pin_case("R8", 3, 1'b0, 6'b010000);
        pin_case("R7", 4, 1'b1, 0);
        pin_case("R7", 20, 1'b1, 0);

        // R8, R6: pin function off
        write_en(1'b0);
        pin_case("R8", 12, 1'b0, 6'b000010);
        run_fault("R6", K_ILAD, 1, 1'b0);

        // Random faults with random enable
        for (int i = 0; i < 8; i++) begin
            kind = int'($urandom % 3);
            hold = 1 + int'($urandom % 6);
            en   = 1'($urandom % 2);
            write_en(en);
            run_fault("R4", kind, hold, en);
            chk("R3", "random enable kept", int'(pin_en), int'(en));
        end

        // R1: asynchronous force mid-cycle
        @(negedge clk);
        #1 por = 1'b1;
        #0.5;
        chk("R1", "core reset forced without clock edge", int'(core_rst), 1);
        @(negedge clk);
        chk("R1", "enable cleared by power-on", int'(pin_en), 0);
        chk("R1", "cause after second power-on", int'(cause), 6'b000001);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule